// File: doc/BRIEF.md
# Channel Fault Qualifier and Retry Controller

This block sits once per output channel of a high-side gate driver and turns three raw comparator flags (open load, over current, short to ground) into qualified faults. A flag only becomes a fault after it has stayed true, without a break, for a programmed number of timebase ticks. Each flag is only looked at in the channel state where it means something. Open load is watched while the channel is commanded off. Over current and short to ground are watched while the gate is on.

The block also decides whether the gate is enabled. After reset it waits a wake-up interval before the channel may switch. After a qualified on-state fault, a mode pin selects one of two behaviours. In latch mode the channel stays off until it is commanded off and then on again. In retry mode the gate stays off for a retry interval and then turns back on for a fresh check.

Every qualified fault raises a one-cycle event pulse for an interrupt latch. It also updates a 2-bit fault code. Timing is counted in ticks of an external timebase strobe (1 µs in the default parameters: 16 ticks for short to ground, 120 ticks times a select-driven multiplier for the other two, 15000 ticks of retry and 512 ticks of wake-up).

Top module: `chan_fault_ctrl`

## Requirements
- R1: After reset is released, the gate stays off and no fault is detected for WAKE_TICKS ticks. With the tick held high every cycle, the gate first turns on at the second clock edge after the wake interval ends, provided the command is high. During reset the gate enable, the fault code and the event output are all 0.
- R2: Once awake, the gate enable follows the channel command one clock edge later, as long as no fault holds the channel off.
- R3: A short-to-ground flag that stays high for STG_TICKS consecutive ticks while the gate is on is qualified. One edge later the fault code becomes 2'b11 and the event output pulses for one cycle.
- R4: An over-current or open-load flag is qualified after OC_BASE_TICKS*(sel+1) consecutive ticks, where sel is the 3-bit deglitch select (0 to 7). The code for over current is 2'b10 and the code for open load is 2'b01.
- R5: If a raw flag drops before its count is complete, the count restarts from zero.
- R6: Open load is evaluated only while the channel is commanded off. It does not change the gate. A flag that stays high continuously gives exactly one event. While the gate is on, the open-load flag has no effect.
- R7: Over current and short to ground have no effect while the channel is off.
- R8: With the retry pin low, a qualified on-state fault turns the gate off. The gate stays off while the command stays high. Only a command low followed by high turns it back on, and that re-enable clears the fault code to 2'b00.
- R9: With the retry pin high, a qualified on-state fault turns the gate off for exactly RETRY_TICKS ticks. The gate then turns on again and checks afresh, which gives a new event if the fault persists.
- R10: If short to ground and over current qualify in the same cycle, the reported code is short to ground (2'b11).
- R11: Deglitch counters advance only on cycles where tick is high. A flag held while tick is low never qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on | input | 1 | Channel command (serial and parallel requests already combined) |
| ol_raw | input | 1 | Raw open-load comparator flag |
| oc_raw | input | 1 | Raw over-current comparator flag |
| stg_raw | input | 1 | Raw short-to-ground comparator flag |
| retry_mode | input | 1 | 1 selects auto-retry, 0 selects latch-off |
| dg_sel | input | 3 | Deglitch multiplier select for open load and over current |
| tick | input | 1 | Timebase strobe, one cycle per time unit |
| gate_en | output | 1 | Gate drive enable |
| fault_code | output | 2 | 00 none, 01 open load, 10 over current, 11 short to ground |
| fault_evt | output | 1 | One-cycle pulse per qualified fault |

## Verification
The bench builds the block with STG_TICKS=3, OC_BASE_TICKS=3, RETRY_TICKS=10 and WAKE_TICKS=5. With these values all eight deglitch settings can be swept for both open load and over current, and the expected qualification edge of each setting is computed arithmetically. Because a select of zero gives the same length as the short-to-ground window, both on-state faults can be made to qualify in the same cycle to test the priority rule. The short retry and wake intervals let the bench count every cycle of the off window and check two retry rounds in a row.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    localparam int SEL_W     = 3;
    localparam int NUM_KINDS = 3;
    localparam int K_OPEN    = 0;
    localparam int K_OVER    = 1;
    localparam int K_SHORT   = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OFF   = 3'd1,
        ST_ON    = 3'd2,
        ST_LATCH = 3'd3,
        ST_RETRY = 3'd4
    } gate_state_e;

    typedef enum logic [1:0] {
        FC_NONE  = 2'b00,
        FC_OPEN  = 2'b01,
        FC_OVER  = 2'b10,
        FC_SHORT = 2'b11
    } fault_code_e;

    // bit order matches the K_* indices
    typedef struct packed {
        logic short_gnd;
        logic over_cur;
        logic open_load;
    } fault_vec_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned scaled_limit(input int unsigned base,
                                                 input logic [SEL_W-1:0] sel);
        return base * (32'(sel) + 32'd1);
    endfunction

    function automatic fault_code_e pick_on_fault(input fault_vec_t h);
        if (h.short_gnd)     return FC_SHORT;
        else if (h.over_cur) return FC_OVER;
        else                 return FC_NONE;
    endfunction

endpackage

// File: rtl/cfc_deglitch.sv
module cfc_deglitch #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             raw,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);

    logic             armed;
    logic             done;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   next_cnt;

    assign armed    = en && raw;
    assign next_cnt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            cnt  <= '0;
            done <= 1'b0;
            hit  <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (tick && !done) begin
                if (next_cnt >= {1'b0, limit}) begin
                    cnt  <= limit;
                    done <= 1'b1;
                    hit  <= 1'b1;
                end else begin
                    cnt <= next_cnt[CNT_W-1:0];
                end
            end
        end
    end

    assert_hit_after_flag_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(armed));

    assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && !$past(tick) && !$past(rst)) |-> $stable(cnt));

endmodule

// File: rtl/cfc_interval.sv
module cfc_interval #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (tick) begin
                if (cnt == CNT_W'(LIMIT - 1)) begin
                    cnt     <= '0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_expire_while_running_R9: assert property (@(posedge clk) disable iff (rst)
        expired |-> $past(run));

endmodule

// File: rtl/cfc_gate_fsm.sv
module cfc_gate_fsm
    import cfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_on,
    input  logic                retry_mode,
    input  logic                wake_done,
    input  logic                retry_done,
    input  fault_vec_t          hits,
    output gate_state_e         state,
    output logic                gate_en,
    output fault_code_e         code,
    output logic                evt
);

    gate_state_e nxt;
    logic        on_fault;

    assign on_fault = hits.short_gnd || hits.over_cur;
    assign gate_en  = (state == ST_ON);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (wake_done) nxt = ST_OFF;
            ST_OFF:   if (cmd_on) nxt = ST_ON;
            ST_ON: begin
                if (!cmd_on)       nxt = ST_OFF;
                else if (on_fault) nxt = retry_mode ? ST_RETRY : ST_LATCH;
            end
            ST_LATCH: if (!cmd_on) nxt = ST_OFF;
            ST_RETRY: begin
                if (!cmd_on)         nxt = ST_OFF;
                else if (retry_done) nxt = ST_ON;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            code  <= FC_NONE;
            evt   <= 1'b0;
        end else begin
            state <= nxt;
            evt   <= 1'b0;
            if (state == ST_ON && on_fault) begin
                code <= pick_on_fault(hits);
                evt  <= 1'b1;
            end else if (state == ST_OFF && hits.open_load) begin
                code <= FC_OPEN;
                evt  <= 1'b1;
            end else if (state == ST_OFF && cmd_on) begin
                code <= FC_NONE;
            end
        end
    end

    assert_latch_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH && cmd_on) |=> (state == ST_LATCH));

    assert_short_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && hits.short_gnd && hits.over_cur) |=> (code == FC_SHORT));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!evt && !gate_en));

    assert_retry_return_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RETRY && retry_done && cmd_on) |=> gate_en);

endmodule

// File: rtl/chan_fault_ctrl.sv
module chan_fault_ctrl
    import cfc_pkg::*;
#(
    parameter int STG_TICKS     = 16,
    parameter int OC_BASE_TICKS = 120,
    parameter int RETRY_TICKS   = 15000,
    parameter int WAKE_TICKS    = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_on,
    input  logic             ol_raw,
    input  logic             oc_raw,
    input  logic             stg_raw,
    input  logic             retry_mode,
    input  logic [SEL_W-1:0] dg_sel,
    input  logic             tick,
    output logic             gate_en,
    output logic [1:0]       fault_code,
    output logic             fault_evt
);

    localparam int MAX_DG = max_u(STG_TICKS, OC_BASE_TICKS * (2 ** SEL_W));
    localparam int CNT_W  = $clog2(MAX_DG + 1);

    gate_state_e          state;
    fault_code_e          code;
    logic                 wake_done;
    logic                 retry_done;
    logic [NUM_KINDS-1:0] arm_en;
    logic [NUM_KINDS-1:0] raw_vec;
    logic [NUM_KINDS-1:0] hit_vec;
    logic [CNT_W-1:0]     lim [NUM_KINDS];
    logic [CNT_W-1:0]     sel_lim;

    assign sel_lim = CNT_W'(scaled_limit(OC_BASE_TICKS, dg_sel));

    assign raw_vec[K_OPEN]  = ol_raw;
    assign raw_vec[K_OVER]  = oc_raw;
    assign raw_vec[K_SHORT] = stg_raw;

    assign arm_en[K_OPEN]  = (state == ST_OFF);
    assign arm_en[K_OVER]  = (state == ST_ON);
    assign arm_en[K_SHORT] = (state == ST_ON);

    assign lim[K_OPEN]  = sel_lim;
    assign lim[K_OVER]  = sel_lim;
    assign lim[K_SHORT] = CNT_W'(STG_TICKS);

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_dg
        cfc_deglitch #(.CNT_W(CNT_W)) u_dg (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .en    (arm_en[k]),
            .raw   (raw_vec[k]),
            .limit (lim[k]),
            .hit   (hit_vec[k])
        );
    end

    cfc_interval #(.LIMIT(WAKE_TICKS)) u_wake (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (state == ST_IDLE),
        .expired (wake_done)
    );

    cfc_interval #(.LIMIT(RETRY_TICKS)) u_retry (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (state == ST_RETRY),
        .expired (retry_done)
    );

    cfc_gate_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_on     (cmd_on),
        .retry_mode (retry_mode),
        .wake_done  (wake_done),
        .retry_done (retry_done),
        .hits       (fault_vec_t'(hit_vec)),
        .state      (state),
        .gate_en    (gate_en),
        .code       (code),
        .evt        (fault_evt)
    );

    assign fault_code = code;

    assert_evt_coded_R6: assert property (@(posedge clk) disable iff (rst)
        fault_evt |-> (fault_code != 2'b00));

    assert_gate_needs_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        gate_en |-> $past(cmd_on));

endmodule

// File: tb/chan_fault_ctrl_tb.sv
module chan_fault_ctrl_tb_top;

    localparam int STG = 3;
    localparam int BASE = 3;
    localparam int RETRY = 10;
    localparam int WAKE = 5;

    logic       clk = 1'b0;
    logic       rst, cmd_on, ol_raw, oc_raw, stg_raw, retry_mode, tick;
    logic [2:0] dg_sel;
    logic       gate_en, fault_evt;
    logic [1:0] fault_code;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    chan_fault_ctrl #(
        .STG_TICKS(STG), .OC_BASE_TICKS(BASE),
        .RETRY_TICKS(RETRY), .WAKE_TICKS(WAKE)
    ) dut_i (
        .clk(clk), .rst(rst), .cmd_on(cmd_on), .ol_raw(ol_raw), .oc_raw(oc_raw),
        .stg_raw(stg_raw), .retry_mode(retry_mode), .dg_sel(dg_sel), .tick(tick),
        .gate_en(gate_en), .fault_code(fault_code), .fault_evt(fault_evt)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // from any awake state: go off, then on (clears code, gate on)
    task automatic rearm();
        ol_raw = 0; oc_raw = 0; stg_raw = 0;
        cmd_on = 0; step(1);
        cmd_on = 1; step(1);
    endtask

    initial begin
        int seen;
        rst = 1; cmd_on = 0; ol_raw = 0; oc_raw = 0; stg_raw = 0;
        retry_mode = 0; tick = 1; dg_sel = 0;
        step(3);
        chk("R1 reset gate", gate_en, 0);
        chk("R1 reset code", fault_code, 0);
        chk("R1 reset evt", fault_evt, 0);

        // R1 wake-up: gate first on after edge WAKE+2
        rst = 0; cmd_on = 1; stg_raw = 1; oc_raw = 1;
        seen = 0;
        for (int k = 1; k <= WAKE + 1; k++) begin
            step(1);
            seen += gate_en + fault_evt;
        end
        chk("R1 quiet during wake", seen, 0);
        stg_raw = 0; oc_raw = 0;
        step(1);
        chk("R1 gate after wake", gate_en, 1);

        // R2 command follow
        cmd_on = 0; step(1);
        chk("R2 gate off", gate_en, 0);
        cmd_on = 1; step(1);
        chk("R2 gate on", gate_en, 1);

        // R4 / R6 open-load sweep over all selects
        for (int s = 0; s < 8; s++) begin
            int lim;
            lim = BASE * (s + 1);
            cmd_on = 0; step(1);
            dg_sel = 3'(s); ol_raw = 1;
            step(lim);
            chk($sformatf("R4 ol sel%0d early evt", s), fault_evt, 0);
            step(1);
            chk($sformatf("R4 ol sel%0d evt", s), fault_evt, 1);
            chk($sformatf("R4 ol sel%0d code", s), fault_code, 1);
            chk($sformatf("R6 ol sel%0d gate", s), gate_en, 0);
            seen = 0;
            for (int k = 0; k < 6; k++) begin step(1); seen += fault_evt; end
            chk($sformatf("R6 ol sel%0d single evt", s), seen, 0);
            rearm();
            chk($sformatf("R8 code cleared sel%0d", s), fault_code, 0);
        end

        // R5 restart after a drop
        dg_sel = 0;
        cmd_on = 0; step(1);
        seen = 0;
        ol_raw = 1; step(2); seen += fault_evt;
        ol_raw = 0; step(1); seen += fault_evt;
        ol_raw = 1;
        for (int k = 0; k < 3; k++) begin step(1); seen += fault_evt; end
        chk("R5 no evt before restart count", seen, 0);
        step(1);
        chk("R5 evt after full window", fault_evt, 1);
        rearm();

        // R7 on-state flags ignored while off
        cmd_on = 0; step(1);
        oc_raw = 1; stg_raw = 1;
        seen = 0;
        for (int k = 0; k < 40; k++) begin step(1); seen += fault_evt; end
        chk("R7 no evt while off", seen, 0);
        chk("R7 code while off", fault_code, 0);
        oc_raw = 0; stg_raw = 0;
        cmd_on = 1; step(1);

        // R6 open-load ignored while on
        ol_raw = 1; seen = 0;
        for (int k = 0; k < 40; k++) begin step(1); seen += fault_evt + (gate_en ? 0 : 1); end
        chk("R6 ol ignored while on", seen, 0);
        chk("R6 code while on", fault_code, 0);
        ol_raw = 0;

        // R3 / R8 short to ground, latch mode
        retry_mode = 0;
        stg_raw = 1; step(STG);
        chk("R3 gate before window", gate_en, 1);
        chk("R3 evt before window", fault_evt, 0);
        step(1);
        chk("R3 gate off", gate_en, 0);
        chk("R3 evt", fault_evt, 1);
        chk("R3 code", fault_code, 3);
        seen = 0;
        for (int k = 0; k < 20; k++) begin step(1); seen += gate_en; end
        stg_raw = 0;
        for (int k = 0; k < 5; k++) begin step(1); seen += gate_en; end
        chk("R8 latched off", seen, 0);
        chk("R8 code held", fault_code, 3);
        rearm();
        chk("R8 re-enable gate", gate_en, 1);
        chk("R8 re-enable code", fault_code, 0);

        // R4 over-current sweep, latch mode
        for (int s = 0; s < 8; s++) begin
            int lim;
            lim = BASE * (s + 1);
            dg_sel = 3'(s); oc_raw = 1;
            step(lim);
            chk($sformatf("R4 oc sel%0d gate early", s), gate_en, 1);
            step(1);
            chk($sformatf("R4 oc sel%0d gate", s), gate_en, 0);
            chk($sformatf("R4 oc sel%0d evt", s), fault_evt, 1);
            chk($sformatf("R4 oc sel%0d code", s), fault_code, 2);
            rearm();
        end

        // R10 both qualify in the same cycle
        dg_sel = 0; oc_raw = 1; stg_raw = 1;
        step(STG + 1);
        chk("R10 evt", fault_evt, 1);
        chk("R10 code short wins", fault_code, 3);
        rearm();

        // R9 retry mode, two rounds
        retry_mode = 1; dg_sel = 0; oc_raw = 1;
        step(BASE);
        chk("R9 gate before fault", gate_en, 1);
        step(1);
        chk("R9 gate off", gate_en, 0);
        chk("R9 evt", fault_evt, 1);
        seen = 0;
        for (int k = 0; k < RETRY; k++) begin step(1); seen += gate_en; end
        chk("R9 off window", seen, 0);
        step(1);
        chk("R9 gate back on", gate_en, 1);
        step(BASE);
        chk("R9 second round gate", gate_en, 1);
        step(1);
        chk("R9 second round off", gate_en, 0);
        chk("R9 second round evt", fault_evt, 1);
        oc_raw = 0;
        step(RETRY + 1);
        chk("R9 recovered", gate_en, 1);
        seen = 0;
        for (int k = 0; k < 10; k++) begin step(1); seen += fault_evt + (gate_en ? 0 : 1); end
        chk("R9 stays on", seen, 0);
        retry_mode = 0;
        rearm();

        // R11 no counting without tick
        tick = 0; oc_raw = 1;
        seen = 0;
        for (int k = 0; k < 30; k++) begin step(1); seen += fault_evt + (gate_en ? 0 : 1); end
        chk("R11 held without tick", seen, 0);
        tick = 1;
        step(BASE);
        chk("R11 evt early", fault_evt, 0);
        step(1);
        chk("R11 evt with tick", fault_evt, 1);
        rearm();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule